// File: doc/BRIEF.md
# Byte-Granular Fuse Memory Read Port

This block is an AHB-Lite subordinate that exposes a one-time-programmable fuse array for reading, one byte at a time. The array is built from `NR_MACROS` fuse macros of 16 bytes each. A legal read returns the addressed byte on the byte lane selected by the two low address bits, with zero wait states. Every other kind of access gets the two-cycle AHB-Lite ERROR response: a write, a read wider than a byte, a read beyond the array, or a read while a program operation is running.

A side port accepts program requests. Each request carries a byte address, a bit mask to set, the current protection state and the requester type. A request that the protection rule allows keeps the block busy for `PROG_CYCLES` cycles. The mask is then ORed into the stored byte, so bits can only ever go from 0 to 1. A request that the rule refuses leaves the array untouched and raises a sticky violation flag.

The fuse array is a behavioural register array that clears to zero at reset.

Top module: `fuse_byte_port`

## Requirements
- R1: Capacity is `NR_MACROS`*16 bytes (128 by default). A NONSEQ or SEQ read with `hsize`=3'b000 at an offset below capacity completes with zero wait states: `hreadyout`=1 and `hresp`=0 in its data phase. The byte appears on `hrdata` bits [8*a+7:8*a], where a=`haddr[1:0]`, and the other lanes are zero.
- R2: After reset, `hreadyout`=1, `hresp`=0, `hrdata`=0, `prog_busy`=0 and `prog_violation`=0, and every byte that has never been programmed reads as 0x00.
- R3: A read with `hsize` other than 3'b000 gets the ERROR response. In the first data-phase cycle `hreadyout`=0 and `hresp`=1. In the second cycle `hreadyout`=1 and `hresp`=1. `hrdata` is 0 in both cycles.
- R4: A write transfer (`hwrite`=1) gets the ERROR response of R3, whatever its size.
- R5: A byte read whose address phase falls in a cycle with `prog_busy`=1 gets the ERROR response of R3.
- R6: A byte read at an offset at or above capacity gets the ERROR response of R3.
- R7: An IDLE (`htrans`=2'b00) or BUSY (2'b01) transfer, or any cycle with `hsel`=0, is answered with `hreadyout`=1, `hresp`=0 and `hrdata`=0 in the following cycle. It does not touch the array.
- R8: A program request is permitted when `prot_secure`=0 (any requester), or when `prot_secure`=1 and `req_debug`=0 (CPU only). It must also address a byte below capacity. A permitted request raises `prog_busy` from the next cycle for exactly `PROG_CYCLES` cycles. After that the stored byte equals its old value ORed with `prog_data`.
- R9: A program request that is not permitted leaves `prog_busy` low and the array unchanged, and sets `prog_violation`. The flag stays at 1 until reset.
- R10: A program request made while `prog_busy`=1 is ignored: the array is not changed and `prog_violation` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Subordinate select |
| haddr | input | HADDR_W | Byte offset within the fuse window |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Write when 1 |
| hsize | input | 3 | Transfer size |
| hready | input | 1 | Bus-wide ready (previous transfer done) |
| hreadyout | output | 1 | Ready from this subordinate |
| hresp | output | 1 | 1 = ERROR response |
| hrdata | output | 32 | Read data, one lane used |
| prog_req | input | 1 | Program request pulse |
| prog_addr | input | HADDR_W | Byte to program |
| prog_data | input | 8 | Bits to set in that byte |
| prot_secure | input | 1 | 1 = secure protection state |
| req_debug | input | 1 | 1 = request from the debug access port |
| prog_busy | output | 1 | Program operation in progress |
| prog_violation | output | 1 | Sticky refused-request flag |

## Verification
The hardest case to reach is a byte read that collides with an active program operation. It needs a permitted request to be accepted, and then a read whose address phase lands inside the busy window. The bench issues the program request and places the byte read in the very next cycle, when `prog_busy` has just risen. It then waits out the window and reads the byte again to confirm that the OR took effect.

A refused request made inside that window is also checked, to show that it neither sets the violation flag nor changes the array.

// File: rtl/fuse_byte_port.sv
module fuse_byte_port #(
  parameter int NR_MACROS   = 8,
  parameter int HADDR_W     = 12,
  parameter int PROG_CYCLES = 4
) (
  input  logic               hclk,
  input  logic               hresetn,
  input  logic               hsel,
  input  logic [HADDR_W-1:0] haddr,
  input  logic [1:0]         htrans,
  input  logic               hwrite,
  input  logic [2:0]         hsize,
  input  logic               hready,
  output logic               hreadyout,
  output logic               hresp,
  output logic [31:0]        hrdata,
  input  logic               prog_req,
  input  logic [HADDR_W-1:0] prog_addr,
  input  logic [7:0]         prog_data,
  input  logic               prot_secure,
  input  logic               req_debug,
  output logic               prog_busy,
  output logic               prog_violation
);
  localparam int CAP = NR_MACROS * 16;
  localparam int AW  = $clog2(CAP);
  localparam int CW  = $clog2(PROG_CYCLES + 1);
  localparam logic [HADDR_W-1:0] CAP_A = HADDR_W'(CAP);

  logic [7:0]    mem [CAP];
  logic          err1, err2;
  logic [31:0]   rdata_q;
  logic [CW-1:0] cnt;
  logic [AW-1:0] pa_q;
  logic [7:0]    pd_q;

  wire accept  = hsel && hready && htrans[1];
  wire bad     = hwrite || (hsize != 3'b000) || (haddr >= CAP_A) || prog_busy;
  wire [7:0] rbyte = (haddr < CAP_A) ? mem[haddr[AW-1:0]] : 8'h00;
  wire [31:0] lane = {24'h0, rbyte} << {haddr[1:0], 3'b000};
  wire permit  = (!prot_secure || !req_debug) && (prog_addr < CAP_A);

  assign hreadyout = !err1;
  assign hresp     = err1 || err2;
  assign hrdata    = rdata_q;

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      err1    <= 1'b0;
      err2    <= 1'b0;
      rdata_q <= '0;
    end else begin
      err1    <= accept && bad;
      err2    <= err1;
      rdata_q <= (accept && !bad) ? lane : 32'h0;
    end
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      prog_busy      <= 1'b0;
      prog_violation <= 1'b0;
      cnt            <= '0;
      pa_q           <= '0;
      pd_q           <= '0;
      for (int i = 0; i < CAP; i++) mem[i] <= 8'h00;
    end else if (prog_busy) begin
      if (cnt == '0) begin
        prog_busy <= 1'b0;
        mem[pa_q] <= mem[pa_q] | pd_q;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (prog_req) begin
      if (permit) begin
        prog_busy <= 1'b1;
        cnt       <= CW'(PROG_CYCLES - 1);
        pa_q      <= prog_addr[AW-1:0];
        pd_q      <= prog_data;
      end else begin
        prog_violation <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fuse_byte_port_chk.sv
module fuse_byte_port_chk (
  input logic        hclk,
  input logic        hresetn,
  input logic        hsel,
  input logic [1:0]  htrans,
  input logic        hwrite,
  input logic        hready,
  input logic        hreadyout,
  input logic        hresp,
  input logic [31:0] hrdata,
  input logic        prog_req,
  input logic        prog_busy,
  input logic        prog_violation
);
  wire active = hsel && hready && htrans[1];

  assert_err_flag_R3: assert property (@(posedge hclk) disable iff (!hresetn)
    !hreadyout |-> hresp);
  assert_err_second_R3: assert property (@(posedge hclk) disable iff (!hresetn)
    !hreadyout |=> (hreadyout && hresp));
  assert_write_err_R4: assert property (@(posedge hclk) disable iff (!hresetn)
    (active && hwrite) |=> (!hreadyout && hresp));
  assert_busy_read_err_R5: assert property (@(posedge hclk) disable iff (!hresetn)
    (active && prog_busy) |=> (!hreadyout && hresp));
  assert_idle_okay_R7: assert property (@(posedge hclk) disable iff (!hresetn)
    (hready && !(hsel && htrans[1])) |=> (hreadyout && !hresp && hrdata == 32'h0));
  assert_one_lane_R1: assert property (@(posedge hclk) disable iff (!hresetn)
    $countones({|hrdata[31:24], |hrdata[23:16], |hrdata[15:8], |hrdata[7:0]}) <= 1);
  assert_busy_start_R8: assert property (@(posedge hclk) disable iff (!hresetn)
    $rose(prog_busy) |-> $past(prog_req));
  assert_sticky_R9: assert property (@(posedge hclk) disable iff (!hresetn)
    prog_violation |=> prog_violation);
  assert_busy_ignore_R10: assert property (@(posedge hclk) disable iff (!hresetn)
    (prog_busy && !prog_violation) |=> !prog_violation);
endmodule

bind fuse_byte_port fuse_byte_port_chk u_chk (
  .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .htrans(htrans), .hwrite(hwrite),
  .hready(hready), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
  .prog_req(prog_req), .prog_busy(prog_busy), .prog_violation(prog_violation)
);

// File: tb/fuse_byte_port_bench.sv
module fuse_byte_port_bench;
  localparam int NRM = 8;
  localparam int AWB = 12;
  localparam int PC  = 4;
  localparam int CAP = NRM * 16;

  logic clk = 0, rstn = 0;
  logic hsel = 0, hwrite = 0, prog_req = 0, prot_secure = 0, req_debug = 0;
  logic [AWB-1:0] haddr = '0, prog_addr = '0;
  logic [1:0] htrans = 2'b00;
  logic [2:0] hsize = 3'b000;
  logic [7:0] prog_data = '0;
  logic hready, hreadyout, hresp, prog_busy, prog_violation;
  logic [31:0] hrdata;

  assign hready = hreadyout;
  always #5 clk = ~clk;

  fuse_byte_port #(.NR_MACROS(NRM), .HADDR_W(AWB), .PROG_CYCLES(PC)) u_fuse_byte_port (
    .hclk(clk), .hresetn(rstn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hready(hready), .hreadyout(hreadyout),
    .hresp(hresp), .hrdata(hrdata), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .prot_secure(prot_secure), .req_debug(req_debug),
    .prog_busy(prog_busy), .prog_violation(prog_violation));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [CAP];

  // {trans[1:0], write, size[2:0], addr[11:0], expect_error}
  localparam logic [18:0] VEC [14] = '{
    {2'b10, 1'b0, 3'd0, 12'd0,    1'b0},
    {2'b10, 1'b0, 3'd0, 12'd5,    1'b0},
    {2'b10, 1'b0, 3'd0, 12'd66,   1'b0},
    {2'b10, 1'b0, 3'd0, 12'd127,  1'b0},
    {2'b10, 1'b0, 3'd0, 12'd10,   1'b0},
    {2'b10, 1'b0, 3'd1, 12'd0,    1'b1},
    {2'b10, 1'b0, 3'd2, 12'd4,    1'b1},
    {2'b10, 1'b1, 3'd0, 12'd5,    1'b1},
    {2'b10, 1'b1, 3'd2, 12'd0,    1'b1},
    {2'b10, 1'b0, 3'd0, 12'd128,  1'b1},
    {2'b10, 1'b0, 3'd0, 12'd4095, 1'b1},
    {2'b00, 1'b0, 3'd0, 12'd5,    1'b0},
    {2'b01, 1'b1, 3'd2, 12'd0,    1'b0},
    {2'b11, 1'b0, 3'd0, 12'd7,    1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_lane(input logic [AWB-1:0] a);
    if (a >= AWB'(CAP)) return 32'h0;
    return {24'h0, model[a]} << (8 * a[1:0]);
  endfunction

  task automatic ahb(input logic [1:0] tr, input logic wr, input logic [2:0] sz,
                     input logic [AWB-1:0] a, input bit exp_err, input string tag);
    logic [31:0] expd;
    @(negedge clk);
    hsel = 1; htrans = tr; hwrite = wr; hsize = sz; haddr = a;
    expd = (tr[1] && !exp_err) ? exp_lane(a) : 32'h0;
    @(negedge clk);
    hsel = 0; htrans = 2'b00; hwrite = 0; hsize = 3'b000;
    if (exp_err) begin
      chk(!hreadyout && hresp && hrdata == 0, {tag, " err cycle1"}, {30'h0, hreadyout, hresp}, 32'h1);
      @(negedge clk);
      chk(hreadyout && hresp && hrdata == 0, {tag, " err cycle2"}, {30'h0, hreadyout, hresp}, 32'h3);
    end else begin
      chk(hreadyout && !hresp, {tag, " okay"}, {30'h0, hreadyout, hresp}, 32'h2);
      chk(hrdata == expd, {tag, " data"}, hrdata, expd);
    end
  endtask

  task automatic prog(input logic [AWB-1:0] a, input logic [7:0] d, input logic sec,
                      input logic dbg, input string tag);
    bit ok = (!sec || !dbg) && (a < AWB'(CAP));
    @(negedge clk);
    prog_req = 1; prog_addr = a; prog_data = d; prot_secure = sec; req_debug = dbg;
    @(negedge clk);
    prog_req = 0;
    chk(prog_busy == ok, {tag, " busy start"}, {31'h0, prog_busy}, {31'h0, ok});
    if (ok) begin
      repeat (PC - 1) @(negedge clk);
      chk(prog_busy == 1, {tag, " busy last"}, {31'h0, prog_busy}, 32'h1);
      @(negedge clk);
      chk(prog_busy == 0, {tag, " busy end"}, {31'h0, prog_busy}, 32'h0);
      model[a] = model[a] | d;
    end else begin
      chk(prog_violation == 1, {tag, " violation"}, {31'h0, prog_violation}, 32'h1);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstn = 0;
    for (int i = 0; i < CAP; i++) model[i] = 8'h00;
    repeat (2) @(negedge clk);
    rstn = 1;
    @(negedge clk);
  endtask

  function automatic string tag_of(input logic [18:0] v);
    if (!v[18]) return "R7";
    if (v[16]) return "R4";
    if (v[15:13] != 0) return "R3";
    if (v[12:1] >= 12'(CAP)) return "R6";
    return "R1";
  endfunction

  initial begin
    do_reset();
    chk(hreadyout && !hresp && hrdata == 0 && !prog_busy && !prog_violation, "R2 reset state",
        {hrdata[29:0], hreadyout, hresp}, 32'h2);
    ahb(2'b10, 0, 3'd0, 12'd33, 0, "R2 unprogrammed");

    prog(12'd0,   8'h81, 1, 0, "R8 secure cpu");
    prog(12'd5,   8'hA5, 0, 1, "R8 normal debug");
    prog(12'd66,  8'h0F, 0, 0, "R8 normal cpu");
    prog(12'd127, 8'h3C, 1, 0, "R8 last byte");

    foreach (VEC[i]) ahb(VEC[i][18:17], VEC[i][16], VEC[i][15:13], VEC[i][12:1], VEC[i][0], tag_of(VEC[i]));

    @(negedge clk);
    hsel = 0; htrans = 2'b10; haddr = 12'd5;
    @(negedge clk);
    htrans = 2'b00;
    chk(hreadyout && !hresp && hrdata == 0, "R7 unselected", hrdata, 32'h0);

    prog(12'd5, 8'h5A, 0, 0, "R8 or-merge");
    ahb(2'b10, 0, 3'd0, 12'd5, 0, "R8 or-merge readback");
    prog(12'd5, 8'h00, 0, 0, "R8 zero mask");
    ahb(2'b10, 0, 3'd0, 12'd5, 0, "R8 zero mask readback");

    @(negedge clk);
    prog_req = 1; prog_addr = 12'd9; prog_data = 8'h77; prot_secure = 0; req_debug = 0;
    @(negedge clk);
    prog_req = 0;
    hsel = 1; htrans = 2'b10; hwrite = 0; hsize = 3'd0; haddr = 12'd9;
    @(negedge clk);
    hsel = 0; htrans = 2'b00;
    chk(!hreadyout && hresp, "R5 read during program", {30'h0, hreadyout, hresp}, 32'h1);
    prog_req = 1; prog_addr = 12'd20; prog_data = 8'hFF; prot_secure = 1; req_debug = 1;
    @(negedge clk);
    prog_req = 0;
    chk(hreadyout && hresp, "R5 err cycle2", {30'h0, hreadyout, hresp}, 32'h3);
    repeat (PC) @(negedge clk);
    chk(!prog_busy && !prog_violation, "R10 request while busy", {30'h0, prog_busy, prog_violation}, 32'h0);
    model[9] = 8'h77;
    ahb(2'b10, 0, 3'd0, 12'd9, 0, "R5 readback after program");
    ahb(2'b10, 0, 3'd0, 12'd20, 0, "R10 array unchanged");

    prog(12'd12, 8'hF0, 1, 1, "R9 secure debug");
    ahb(2'b10, 0, 3'd0, 12'd12, 0, "R9 array unchanged");
    prog(12'd13, 8'h01, 0, 0, "R9 sticky after good program");
    chk(prog_violation == 1, "R9 sticky", {31'h0, prog_violation}, 32'h1);

    do_reset();
    chk(!prog_violation, "R2 violation cleared", {31'h0, prog_violation}, 32'h0);
    ahb(2'b10, 0, 3'd0, 12'd5, 0, "R2 cleared byte");
    prog(12'd200, 8'h01, 0, 0, "R9 out of range program");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule